// File: doc/BRIEF.md
# Accumulate, Round, Window and Clamp Output Stage

This block is the back end of a multiply-accumulate datapath. Every clock it receives a 32-bit signed sum of products. It either starts a new running total with that sum or adds the sum to the total it already holds. It then adds a signed rounding offset taken from one of sixteen 32-bit offset registers, and cuts a 16-bit window out of the rounded word at a programmable bit position. Last, it can clamp that window between a lower and an upper bound taken from one of sixteen limit registers. The result goes to a registered 16-bit output.

The offset and limit register contents arrive as flat input buses, so the block holds no programmable storage of its own. All control inputs travel down the pipeline with the sum they arrive with. A change in offset select, shift, limit select, clamp enable or output hold therefore takes effect exactly on the sample presented in the same cycle. The stage has two register levels: the accumulator, then the output register.

The accumulator has two modes, `ACC_LOAD` and `ACC_ADD`. The mode is chosen by the accumulate input on each cycle, with no other sequencing. `ACC_LOAD` goes to `ACC_ADD` when the input is HIGH, and `ACC_ADD` goes back to `ACC_LOAD` when it is LOW.

Top module: `sop_output_stage`

## Requirements
- R1: When `acc_en` is LOW on a sampled cycle, the accumulator takes the new `sop_in` value alone and discards its earlier total.
- R2: When `acc_en` is HIGH on a sampled cycle, the accumulator becomes its earlier total plus `sop_in`.
- R3: The offset register selected by `rnd_sel` is added to the accumulator as a signed 32-bit value. Register i occupies bits 32*i+31 down to 32*i of `rnd_regs`.
- R4: A `shift_sel` value n passes bits n+15 down to n of the rounded word. Any value above 16 acts as 16.
- R5: When `clamp_n` is HIGH, the window passes to the output unchanged.
- R6: When `clamp_n` is LOW, the window is clamped using the limit register chosen by `lim_sel`. Register i occupies 32 bits of `lim_regs` starting at bit 32*i, with the upper bound in the top half and the lower bound in the bottom half. All comparisons are signed. A window above the upper bound gives the upper bound. Otherwise, a window below the lower bound gives the lower bound.
- R7: When `out_hold` is LOW, the output register loads. When it is HIGH, the output keeps its value.
- R8: Accumulation and rounding wrap modulo 2^32.
- R9: Control inputs are sampled together with `sop_in`. The result of a sample appears on `dout` after the second rising edge that follows its presentation.
- R10: While `rst_n` is LOW, the accumulator and `dout` clear to zero and the output register is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sop_in | input | 32 | Signed sum of products for this cycle |
| acc_en | input | 1 | HIGH adds to the running total, LOW restarts it |
| rnd_sel | input | 4 | Offset register select |
| shift_sel | input | 5 | Low bit index of the 16-bit output window |
| lim_sel | input | 4 | Limit register select |
| clamp_n | input | 1 | Active-low clamp enable |
| out_hold | input | 1 | HIGH freezes the output register |
| rnd_regs | input | 512 | Sixteen 32-bit signed offsets, register 0 at bit 0 |
| lim_regs | input | 512 | Sixteen {upper, lower} signed 16-bit bound pairs |
| dout | output | 16 | Registered result |

## Verification
A sample and its controls, presented before edge k, update the accumulator at edge k and reach `dout` at edge k+1. The bench therefore compares the value seen after edge k+1 with the expectation for the sample driven one iteration earlier. In the vector table, inputs are driven on the falling edge and `dout` is read on the next falling edge, one cycle behind the stimulus. An output hold is checked on the cycle the held sample would have loaded. The directed tests observe the one-cycle gap before a result appears and the reset clear at the same sampling points.

// File: rtl/sop_stage_pkg.sv
package sop_stage_pkg;

    typedef enum logic {
        ACC_LOAD = 1'b0,
        ACC_ADD  = 1'b1
    } acc_mode_e;

endpackage

// File: rtl/sop_accum.sv
module sop_accum
    import sop_stage_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  acc_mode_e               mode,
    input  logic signed [ACC_W-1:0] sop,
    output logic signed [ACC_W-1:0] acc_q
);

    logic signed [ACC_W-1:0] acc_d;

    always_comb begin
        unique case (mode)
            ACC_LOAD: acc_d = sop;
            ACC_ADD:  acc_d = acc_q + sop;
            default:  acc_d = sop;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R1: a restart discards the previous total
    a_r1_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ACC_LOAD) |=> (acc_q == $past(sop)));

    // R2, R8: running sum, wrapping at the accumulator width
    a_r2_add_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ACC_ADD) |=> (acc_q == $past(acc_q) + $past(sop)));

endmodule

// File: rtl/sop_round_window.sv
module sop_round_window #(
    parameter int ACC_W = 32,
    parameter int OUT_W = 16,
    parameter int NREG  = 16,
    parameter int SEL_W = $clog2(NREG),
    parameter int SH_W  = 5
) (
    input  logic signed [ACC_W-1:0]      acc,
    input  logic        [NREG*ACC_W-1:0] rnd_flat,
    input  logic        [SEL_W-1:0]      rsel,
    input  logic        [SH_W-1:0]       shift,
    output logic signed [OUT_W-1:0]      win
);

    localparam int              MAX_SH   = ACC_W - OUT_W;
    localparam logic [SH_W-1:0] MAX_SH_V = SH_W'(MAX_SH);

    logic signed [ACC_W-1:0] offs [NREG];
    logic signed [ACC_W-1:0] rounded;
    logic        [SH_W-1:0]  sh_eff;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_offs
            assign offs[g] = rnd_flat[g*ACC_W +: ACC_W];
        end
    endgenerate

    assign rounded = acc + offs[rsel];
    assign sh_eff  = (shift > MAX_SH_V) ? MAX_SH_V : shift;
    assign win     = OUT_W'(rounded >>> sh_eff);

endmodule

// File: rtl/sop_limiter.sv
module sop_limiter #(
    parameter int OUT_W = 16,
    parameter int NREG  = 16,
    parameter int SEL_W = $clog2(NREG)
) (
    input  logic signed [OUT_W-1:0]        din,
    input  logic        [NREG*2*OUT_W-1:0] lim_flat,
    input  logic        [SEL_W-1:0]        lsel,
    input  logic                           clamp_n,
    output logic signed [OUT_W-1:0]        y
);

    localparam int PAIR_W = 2 * OUT_W;

    logic signed [OUT_W-1:0] hi_arr [NREG];
    logic signed [OUT_W-1:0] lo_arr [NREG];
    logic signed [OUT_W-1:0] hi;
    logic signed [OUT_W-1:0] lo;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_lim
            assign hi_arr[g] = lim_flat[g*PAIR_W + OUT_W +: OUT_W];
            assign lo_arr[g] = lim_flat[g*PAIR_W +: OUT_W];
        end
    endgenerate

    assign hi = hi_arr[lsel];
    assign lo = lo_arr[lsel];

    always_comb begin
        y = din;
        if (!clamp_n) begin
            if (din > hi)      y = hi;
            else if (din < lo) y = lo;
        end
    end

    // R6: a consistent bound pair always contains the clamped value
    always_comb begin
        if (!clamp_n && (lo <= hi)) begin
            a_r6_in_bounds: assert ((y <= hi) && (y >= lo))
                else $error("clamped value outside bounds");
        end
    end

endmodule

// File: rtl/sop_output_stage.sv
module sop_output_stage
    import sop_stage_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int OUT_W = 16,
    parameter int NREG  = 16,
    parameter int SEL_W = $clog2(NREG),
    parameter int SH_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ACC_W-1:0]        sop_in,
    input  logic                    acc_en,
    input  logic [SEL_W-1:0]        rnd_sel,
    input  logic [SH_W-1:0]         shift_sel,
    input  logic [SEL_W-1:0]        lim_sel,
    input  logic                    clamp_n,
    input  logic                    out_hold,
    input  logic [NREG*ACC_W-1:0]   rnd_regs,
    input  logic [NREG*2*OUT_W-1:0] lim_regs,
    output logic [OUT_W-1:0]        dout
);

    acc_mode_e               mode;
    logic signed [ACC_W-1:0] acc_q;
    logic        [SEL_W-1:0] rsel_q;
    logic        [SH_W-1:0]  shift_q;
    logic        [SEL_W-1:0] lsel_q;
    logic                    clamp_n_q;
    logic                    hold_q;
    logic signed [OUT_W-1:0] win;
    logic signed [OUT_W-1:0] lim_y;

    assign mode = acc_en ? ACC_ADD : ACC_LOAD;

    // controls travel alongside the accumulated sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsel_q    <= '0;
            shift_q   <= '0;
            lsel_q    <= '0;
            clamp_n_q <= 1'b1;
            hold_q    <= 1'b1;
        end else begin
            rsel_q    <= rnd_sel;
            shift_q   <= shift_sel;
            lsel_q    <= lim_sel;
            clamp_n_q <= clamp_n;
            hold_q    <= out_hold;
        end
    end

    sop_accum #(.ACC_W(ACC_W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .sop   (sop_in),
        .acc_q (acc_q)
    );

    sop_round_window #(
        .ACC_W(ACC_W), .OUT_W(OUT_W), .NREG(NREG), .SEL_W(SEL_W), .SH_W(SH_W)
    ) u_window (
        .acc      (acc_q),
        .rnd_flat (rnd_regs),
        .rsel     (rsel_q),
        .shift    (shift_q),
        .win      (win)
    );

    sop_limiter #(.OUT_W(OUT_W), .NREG(NREG), .SEL_W(SEL_W)) u_limit (
        .din      (win),
        .lim_flat (lim_regs),
        .lsel     (lsel_q),
        .clamp_n  (clamp_n_q),
        .y        (lim_y)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      dout <= '0;
        else if (!hold_q) dout <= lim_y;
    end

    // R7: enabled output register takes the limiter result
    a_r7_loads: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_q |=> (dout == $past(lim_y)));

    // R7: held output register keeps its value
    a_r7_holds: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> $stable(dout));

endmodule

// File: tb/sop_output_stage_tb.sv
module sop_output_stage_tb;

    localparam int CLK_P    = 10;
    localparam int NV       = 20;
    localparam int WD_CYCLES = 20000;

    typedef struct packed {
        logic        acc;
        logic [31:0] sop;
        logic [3:0]  rs;
        logic [4:0]  sh;
        logic [3:0]  ls;
        logic        cln;
        logic        st;
        logic [15:0] exp;
    } vec_t;

    // acc, sop, rnd_sel, shift, lim_sel, clamp_n, out_hold, expected dout
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'd100,       4'd0, 5'd0,  4'd0, 1'b1, 1'b0, 16'h0064}, // R1 restart
        '{1'b1, 32'd50,        4'd0, 5'd0,  4'd0, 1'b1, 1'b0, 16'h0096}, // R2 add
        '{1'b1, 32'hFFFFFFE2,  4'd0, 5'd0,  4'd0, 1'b1, 1'b0, 16'h0078}, // R2 add negative
        '{1'b0, 32'h00012345,  4'd0, 5'd4,  4'd0, 1'b1, 1'b0, 16'h1234}, // R4 shift 4
        '{1'b0, 32'h00012345,  4'd2, 5'd0,  4'd0, 1'b1, 1'b0, 16'h2346}, // R3 offset +1
        '{1'b0, 32'h12345678,  4'd0, 5'd16, 4'd0, 1'b1, 1'b0, 16'h1234}, // R4 shift 16
        '{1'b0, 32'h12345678,  4'd0, 5'd31, 4'd0, 1'b1, 1'b0, 16'h1234}, // R4 shift capped
        '{1'b0, 32'h0000FFFF,  4'd1, 5'd16, 4'd0, 1'b1, 1'b0, 16'h0001}, // R3 half-lsb offset
        '{1'b0, 32'd500,       4'd0, 5'd0,  4'd1, 1'b0, 1'b0, 16'h0064}, // R6 upper clamp
        '{1'b0, 32'hFFFFFE0C,  4'd0, 5'd0,  4'd1, 1'b0, 1'b0, 16'hFF9C}, // R6 lower clamp
        '{1'b0, 32'd50,        4'd0, 5'd0,  4'd1, 1'b0, 1'b0, 16'h0032}, // R6 inside range
        '{1'b0, 32'd500,       4'd0, 5'd0,  4'd1, 1'b1, 1'b0, 16'h01F4}, // R5 bypass
        '{1'b0, 32'h7FFFFFFF,  4'd0, 5'd0,  4'd0, 1'b1, 1'b0, 16'hFFFF}, // R1 max positive
        '{1'b1, 32'h00000001,  4'd0, 5'd16, 4'd0, 1'b1, 1'b0, 16'h8000}, // R8 wrap
        '{1'b0, 32'h00000024,  4'd3, 5'd0,  4'd0, 1'b1, 1'b0, 16'h0023}, // R3 offset -1
        '{1'b0, 32'h00000999,  4'd0, 5'd0,  4'd0, 1'b1, 1'b1, 16'h0023}, // R7 hold
        '{1'b0, 32'h00000007,  4'd0, 5'd0,  4'd0, 1'b1, 1'b0, 16'h0007}, // R7 load again
        '{1'b0, 32'h00000018,  4'd0, 5'd0,  4'd2, 1'b0, 1'b0, 16'h0010}, // R6 upper has priority
        '{1'b0, 32'h00000005,  4'd0, 5'd0,  4'd2, 1'b0, 1'b0, 16'h0020}, // R6 lower on inverted pair
        '{1'b0, 32'hFFFF8000,  4'd0, 5'd0,  4'd0, 1'b0, 1'b0, 16'h8000}  // R6 signed compare
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [31:0]  sop_in;
    logic         acc_en;
    logic [3:0]   rnd_sel;
    logic [4:0]   shift_sel;
    logic [3:0]   lim_sel;
    logic         clamp_n;
    logic         out_hold;
    logic [511:0] rnd_regs;
    logic [511:0] lim_regs;
    logic [15:0]  dout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sop_output_stage u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sop_in    (sop_in),
        .acc_en    (acc_en),
        .rnd_sel   (rnd_sel),
        .shift_sel (shift_sel),
        .lim_sel   (lim_sel),
        .clamp_n   (clamp_n),
        .out_hold  (out_hold),
        .rnd_regs  (rnd_regs),
        .lim_regs  (lim_regs),
        .dout      (dout)
    );

    task automatic chk(input string req, input logic [15:0] exp);
        checks++;
        if (dout !== exp) begin
            errors++;
            $display("FAIL %s: dout=%h expected %h", req, dout, exp);
        end
    endtask

    task automatic drive(input logic a, input logic [31:0] s, input logic [3:0] rs,
                         input logic [4:0] sh, input logic [3:0] ls,
                         input logic cln, input logic st);
        acc_en = a; sop_in = s; rnd_sel = rs; shift_sel = sh;
        lim_sel = ls; clamp_n = cln; out_hold = st;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rnd_regs = '0;
        lim_regs = '0;
        for (int i = 0; i < 16; i++) lim_regs[i*32 +: 32] = {16'h7FFF, 16'h8000};
        rnd_regs[1*32 +: 32] = 32'h0000_8000;
        rnd_regs[2*32 +: 32] = 32'h0000_0001;
        rnd_regs[3*32 +: 32] = 32'hFFFF_FFFF;
        lim_regs[1*32 +: 32] = {16'h0064, 16'hFF9C};
        lim_regs[2*32 +: 32] = {16'h0010, 16'h0020};

        rst_n = 1'b0;
        drive(1'b1, 32'h0000_1111, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        @(negedge clk);
        step();
        step();
        chk("R10 reset clears output", 16'h0000);
        rst_n = 1'b1;

        // table walk: result of vector i-1 is due after the edge that samples vector i
        for (int i = 0; i <= NV; i++) begin
            if (i < NV)
                drive(VECS[i].acc, VECS[i].sop, VECS[i].rs, VECS[i].sh,
                      VECS[i].ls, VECS[i].cln, VECS[i].st);
            else
                drive(1'b0, 32'h0, 4'd0, 5'd0, 4'd0, 1'b1, 1'b1);
            step();
            if (i > 0) chk($sformatf("R9 table vector %0d", i-1), VECS[i-1].exp);
        end

        // R9: one full cycle passes before a sample reaches dout
        drive(1'b0, 32'h11, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        step();
        drive(1'b0, 32'h22, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        chk("R9 result not yet due", 16'h8000);
        step();
        chk("R9 result due after second edge", 16'h0011);

        // R7: several held cycles with changing data
        drive(1'b0, 32'h42, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        step();
        drive(1'b0, 32'h77, 4'd0, 5'd0, 4'd0, 1'b1, 1'b1);
        step();
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, 32'h100 + 32'(k), 4'd0, 5'd0, 4'd0, 1'b1, 1'b1);
            step();
            chk("R7 output held", 16'h0042);
        end

        // R10: reset in the middle of an accumulation clears the total
        drive(1'b1, 32'h55, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        step();
        step();
        rst_n = 1'b0;
        step();
        chk("R10 reset mid-run", 16'h0000);
        rst_n = 1'b1;
        drive(1'b1, 32'h5, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        step();
        drive(1'b0, 32'h0, 4'd0, 5'd0, 4'd0, 1'b1, 1'b1);
        step();
        chk("R10 accumulator cleared by reset", 16'h0005);

        finish_run();
    end

endmodule